// File: doc/BRIEF.md
# Tamper Event Latch with Time Capture

This block watches an asynchronous tamper input for a rising edge. When it sees one, it sets a sticky tamper flag, which software reads as bit 7 of the flags register. Any later edges are ignored until software writes that bit back to 0, and the write re-arms detection. The hardware never clears the flag on its own.

When the timestamp enable input is high at the moment an event is accepted, the block copies the live calendar value from the clock core into a holding snapshot. Software can then read the time of the event from that snapshot. The block raises a one-cycle capture strobe with each such copy.

The same snapshot also serves ordinary time reads. Writing the read-request bit (bit 0 of the flags register) from 0 to 1 refreshes the snapshot with the current time. That refresh overwrites any stored event time.

Top module: `tamper_timestamp`

## Requirements
- R1: After reset the tamper flag is 0, the capture strobe is 0 and every snapshot bit is 0.
- R2: A rising edge on the tamper input sets the flag. The flag is still 0 two clock edges after the input changes and is 1 after the third edge: two synchroniser stages, then the flag register.
- R3: A falling edge on the tamper input never sets the flag and never causes a capture.
- R4: While the flag is set, further rising edges cause no capture strobe and leave the snapshot unchanged.
- R5: The flag is cleared only by a write to address 0 with data bit 7 equal to 0. A write to address 0 with bit 7 equal to 1, or a write to any other address, leaves the flag unchanged.
- R6: Without a clearing write, the flag stays set indefinitely.
- R7: If a clearing write and an accepted rising edge fall in the same cycle, the edge wins. The flag stays 1 and the event is treated as new, including a capture when enabled.
- R8: An accepted event with the timestamp enable high loads the snapshot with the live time present in the cycle of acceptance. It also drives the capture strobe high for the following cycle.
- R9: An accepted event with the timestamp enable low still sets the flag, but gives no strobe and leaves the snapshot unchanged.
- R10: A write to address 0 whose bit 0 is 1, while the stored read-request bit is 0, loads the snapshot with the current live time. A repeated write of 1 does not reload the snapshot. Writing 0 and then 1 reloads it.
- R11: One physical rising edge produces exactly one strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_in | input | 1 | Asynchronous tamper sense input |
| ts_enable | input | 1 | Timestamp enable bit from the control register |
| live_time | input | 56 | Live calendar value from the clock core, seven 8-bit fields |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| tamper_flag | output | 1 | Sticky tamper flag (flags register bit 7) |
| ts_strobe | output | 1 | One-cycle pulse after an event capture |
| snap_time | output | 56 | Readable time snapshot |

## Verification
Each result arrives at a fixed cycle:
- A tamper input change reaches the flag register on the third clock edge after the change. The capture strobe and the event snapshot change on that same edge.
- A register write acts on the first edge after it is presented.

The bench drives every input on the falling clock edge and reads the outputs on a later falling edge, after exactly the number of rising edges needed. Strobes are counted by a sampling process at the rising edge, so every pulse is tallied once.

The sweep places the clearing write at each cycle offset around the accepting edge: before it, on it and after it. It does this with the timestamp enable both low and high, and the expected flag, strobe count and snapshot for each case are worked out in the bench from the offset.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  // Picks one bit out of a written word; index is a field position.
  function automatic logic pick_bit(logic [31:0] word, int unsigned idx);
    return word[idx];
  endfunction

  // Flag update: a new edge dominates a clearing write.
  function automatic logic flag_next(logic flag, logic rise, logic clr);
    return rise | (flag & ~clr);
  endfunction

  // An edge is accepted when the flag is free or being released this cycle.
  function automatic logic edge_accepted(logic flag, logic rise, logic clr);
    return rise & (~flag | clr);
  endfunction

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= async_in;
      end
      assign sync_out = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tamper_edge.sv
module tamper_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end
  assign rise_o = level_in & ~prev_q;
endmodule

// File: rtl/tamper_flag_ctl.sv
module tamper_flag_ctl
  import tamper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic clr_i,
  output logic flag_o,
  output logic accept_o
);
  logic flag_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, rise_i, clr_i);
  end
  assign flag_o   = flag_q;
  assign accept_o = edge_accepted(flag_q, rise_i, clr_i);
endmodule

// File: rtl/time_snapshot.sv
module time_snapshot #(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] live_i,
  output logic [NUM_FIELDS*FIELD_W-1:0] snap_o
);
  generate
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic [FIELD_W-1:0] field_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      field_q <= '0;
        else if (load_i) field_q <= live_i[f*FIELD_W +: FIELD_W];
      end
      assign snap_o[f*FIELD_W +: FIELD_W] = field_q;
    end
  endgenerate
endmodule

// File: rtl/tamper_timestamp.sv
module tamper_timestamp
  import tamper_pkg::*;
#(
  parameter int NUM_FIELDS  = 7,
  parameter int FIELD_W     = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_ADDR   = 0,
  parameter int FLAG_BIT    = 7,
  parameter int RSNAP_BIT   = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tamper_in,
  input  logic                          ts_enable,
  input  logic [NUM_FIELDS*FIELD_W-1:0] live_time,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          tamper_flag,
  output logic                          ts_strobe,
  output logic [NUM_FIELDS*FIELD_W-1:0] snap_time
);
  localparam int TIME_W = NUM_FIELDS * FIELD_W;

  // Named internal events, brought out for the checker.
  logic tamper_sync_lvl;
  logic rise_evt;
  logic accept_evt;
  logic flags_wr;
  logic clr_req;
  logic rsnap_val;
  logic rsnap_rise;
  logic ts_take;
  logic snap_load;
  logic rsnap_q;
  logic strobe_q;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tamper_in),
    .sync_out (tamper_sync_lvl)
  );

  tamper_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (tamper_sync_lvl),
    .rise_o   (rise_evt)
  );

  assign flags_wr  = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));
  assign clr_req   = flags_wr && !pick_bit(32'(wr_data), FLAG_BIT);
  assign rsnap_val = pick_bit(32'(wr_data), RSNAP_BIT);

  tamper_flag_ctl u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise_evt),
    .clr_i    (clr_req),
    .flag_o   (tamper_flag),
    .accept_o (accept_evt)
  );

  // Read-request bit: a 0-to-1 write refreshes the snapshot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsnap_q <= 1'b0;
    else if (flags_wr) rsnap_q <= rsnap_val;
  end
  assign rsnap_rise = flags_wr && rsnap_val && !rsnap_q;

  assign ts_take   = accept_evt && ts_enable;
  assign snap_load = ts_take || rsnap_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= ts_take;
  end
  assign ts_strobe = strobe_q;

  time_snapshot #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (snap_load),
    .live_i (live_time[TIME_W-1:0]),
    .snap_o (snap_time)
  );
endmodule

// File: rtl/tamper_timestamp_chk.sv
module tamper_timestamp_chk #(
  parameter int TIME_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_evt,
  input logic              accept_evt,
  input logic              clr_req,
  input logic              rsnap_rise,
  input logic              snap_load,
  input logic              tamper_flag,
  input logic              ts_strobe,
  input logic              ts_enable,
  input logic [TIME_W-1:0] live_time,
  input logic [TIME_W-1:0] snap_time
);
  assert_edge_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> tamper_flag);

  assert_no_set_without_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tamper_flag && !rise_evt) |=> !tamper_flag);

  assert_ignore_while_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_flag && !clr_req) |-> !accept_evt);

  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !rise_evt) |=> !tamper_flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_flag && !clr_req) |=> tamper_flag);

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && clr_req) |=> tamper_flag);

  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && ts_enable) |=> (ts_strobe && snap_time == $past(live_time)));

  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(snap_time));

  assert_read_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsnap_rise |=> snap_time == $past(live_time));

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe |=> !ts_strobe);
endmodule

bind tamper_timestamp tamper_timestamp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise_evt    (rise_evt),
  .accept_evt  (accept_evt),
  .clr_req     (clr_req),
  .rsnap_rise  (rsnap_rise),
  .snap_load   (snap_load),
  .tamper_flag (tamper_flag),
  .ts_strobe   (ts_strobe),
  .ts_enable   (ts_enable),
  .live_time   (live_time),
  .snap_time   (snap_time)
);

// File: tb/tamper_timestamp_bench.sv
module tamper_timestamp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tamper_in = 1'b0;
  logic        ts_enable = 1'b0;
  logic [55:0] live_time = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tamper_flag;
  logic        ts_strobe;
  logic [55:0] snap_time;

  int checks = 0;
  int fails = 0;
  int strobe_total = 0;
  logic [55:0] exp_snap = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tamper_timestamp u_tamper_timestamp (
    .clk (clk), .rst_n (rst_n), .tamper_in (tamper_in), .ts_enable (ts_enable),
    .live_time (live_time), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .tamper_flag (tamper_flag), .ts_strobe (ts_strobe), .snap_time (snap_time)
  );

  always @(posedge clk) if (ts_strobe) strobe_total <= strobe_total + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    @(negedge clk); cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check(tamper_flag == 1'b0, "R1 flag", 64'(tamper_flag), 0);
    check(ts_strobe == 1'b0, "R1 strobe", 64'(ts_strobe), 0);
    check(snap_time == '0, "R1 snap", 64'(snap_time), 0);

    // R2 latency, R9 no capture with enable low
    live_time = 56'h24_06_15_03_12_30_45;
    base = strobe_total;
    tamper_in = 1'b1;
    cyc(2);
    check(tamper_flag == 1'b0, "R2 latency", 64'(tamper_flag), 0);
    cyc(1);
    check(tamper_flag == 1'b1, "R2 set", 64'(tamper_flag), 1);
    cyc(3);
    check(snap_time == exp_snap, "R9 snap", 64'(snap_time), 64'(exp_snap));
    check(strobe_total == base, "R9 strobe", 64'(strobe_total - base), 0);

    // R6 stays set
    cyc(60);
    check(tamper_flag == 1'b1, "R6 sticky", 64'(tamper_flag), 1);

    // R4 later edges ignored while set
    ts_enable = 1'b1;
    base = strobe_total;
    tamper_in = 1'b0; cyc(4); tamper_in = 1'b1; cyc(6);
    check(strobe_total == base, "R4 strobe", 64'(strobe_total - base), 0);
    check(snap_time == exp_snap, "R4 snap", 64'(snap_time), 64'(exp_snap));

    // R5 clearing rules
    wr(4'd0, 8'h80);
    check(tamper_flag == 1'b1, "R5 bit7 one", 64'(tamper_flag), 1);
    wr(4'd3, 8'h00);
    check(tamper_flag == 1'b1, "R5 other addr", 64'(tamper_flag), 1);
    wr(4'd0, 8'h00);
    check(tamper_flag == 1'b0, "R5 clear", 64'(tamper_flag), 0);

    // R3 falling edge ignored
    base = strobe_total;
    tamper_in = 1'b0; cyc(6);
    check(tamper_flag == 1'b0, "R3 flag", 64'(tamper_flag), 0);
    check(strobe_total == base, "R3 strobe", 64'(strobe_total - base), 0);

    // R8 / R11 capture
    live_time = 56'h25_01_31_05_23_59_58;
    base = strobe_total;
    tamper_in = 1'b1; cyc(3);
    exp_snap = live_time;
    check(ts_strobe == 1'b1, "R8 strobe", 64'(ts_strobe), 1);
    check(snap_time == exp_snap, "R8 snap", 64'(snap_time), 64'(exp_snap));
    live_time = 56'h99_12_31_07_00_00_01;
    cyc(4);
    check(strobe_total - base == 1, "R11 one pulse", 64'(strobe_total - base), 1);
    check(snap_time == exp_snap, "R8 held", 64'(snap_time), 64'(exp_snap));

    // R10 read-request refresh
    live_time = 56'h30_02_28_02_08_15_20;
    wr(4'd0, 8'h81); exp_snap = 56'h30_02_28_02_08_15_20;
    check(snap_time == exp_snap, "R10 refresh", 64'(snap_time), 64'(exp_snap));
    check(tamper_flag == 1'b1, "R5 keep on 0x81", 64'(tamper_flag), 1);
    live_time = 56'h31_03_01_03_09_16_21;
    wr(4'd0, 8'h81);
    check(snap_time == exp_snap, "R10 no repeat", 64'(snap_time), 64'(exp_snap));
    wr(4'd0, 8'h80); wr(4'd0, 8'h81); exp_snap = live_time;
    check(snap_time == exp_snap, "R10 rearm", 64'(snap_time), 64'(exp_snap));

    // R7 sweep: clearing write offset around the accepting edge
    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 6; k++) begin
        wr(4'd0, 8'h00);
        tamper_in = 1'b0; ts_enable = en[0]; cyc(4);
        live_time = {8'h40, 8'(k), 8'(en), 32'h0A0B0C0D};
        base = strobe_total;
        tamper_in = 1'b1;
        for (int j = 0; j < 8; j++) begin
          if (j == k) begin wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h00; end
          else wr_en = 1'b0;
          cyc(1);
        end
        wr_en = 1'b0;
        if (en == 1) exp_snap = {8'h40, 8'(k), 8'(en), 32'h0A0B0C0D};
        check(tamper_flag == (k <= 2), "R7 flag vs clear offset",
              64'(tamper_flag), 64'(k <= 2));
        check(strobe_total - base == en, "R7 strobe count",
              64'(strobe_total - base), 64'(en));
        check(snap_time == exp_snap, "R7 snap", 64'(snap_time), 64'(exp_snap));
      end
    end
    summary();
  end
endmodule